// File: doc/BRIEF.md
# Multi-Mode Load/Store Address Generator

This unit forms the effective address for a data access or a branch in a small RISC load/store pipeline. Each cycle it can take a base register value and its register number, an index register value, a signed immediate, the program counter, an access size, an instruction-length flag, a shift amount and a mode code. One clock later it presents the address, a misalignment flag and, for the modes that update the base register, the value to write back and an enable for that write.

The unit covers both fixed-length and compact encodings. It provides plain displacement, register indirect, indexed and scaled-index forms. It also provides a compact-offset form whose immediate scales with the access size, and PC-relative targets scaled by the instruction length. Update forms write the new address back to the base register, and there are post-increment and pre-decrement forms that step by the access size. Register number 0 reads as zero when used as a base, so absolute addressing needs no mode of its own. The unit reports a misaligned address but does not trap.

Top module: `agu_top`

## Requirements
- R1: All outputs are registered with one cycle of latency. `out_valid` equals `in_valid` from the previous edge. Reset (synchronous, active high) clears every output to zero. Whenever `out_valid` is 0, `addr`, `wb_data`, `wb_en` and `misaligned` are 0.
- R2: When `base_sel` is 0, the base operand is zero whatever `base_val` holds. Displacement mode with base number 0 therefore yields the sign-extended immediate as an absolute address.
- R3: Mode 0 (displacement) gives base + sign-extended immediate. Mode 1 (indirect) gives the base alone and ignores the immediate. Mode codes 11 to 15 behave as mode 0.
- R4: Mode 2 (indexed) gives base + index. Mode 3 (scaled index) gives base + (index << `shamt`), for `shamt` from 0 to 31.
- R5: Mode 9 (compact offset) gives base + (sign-extended immediate << k). k is 0 for size code 0 (byte), 1 for code 1 (halfword), and 2 for codes 2 and 3 (word).
- R6: Mode 10 (PC-relative) gives `pc` + (sign-extended immediate << 2) when `short_insn` is 0, and << 1 when it is 1. It never writes back.
- R7: Mode 4 (scaled with update), mode 5 (displacement with update) and mode 6 (indexed with update) output the computed address, and also return that same address on `wb_data`.
- R8: Mode 7 (post-increment) outputs the old base and writes back base + size. Mode 8 (pre-decrement) outputs base − size and writes back that same value. The size in bytes is 1, 2, 4 or 4 for size codes 0, 1, 2 and 3.
- R9: `wb_en` is 1 only for modes 4 to 8 with a nonzero `base_sel`. When `wb_en` is 0, `wb_data` is 0.
- R10: `misaligned` is 1 when the output address is not a multiple of the access size: bit 0 set for size code 1, or either of bits 1:0 set for size codes 2 and 3. It is never set for size code 0.
- R11: The immediate is sign-extended before any scaling, and all sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 4 | Addressing mode code |
| base_sel | input | 5 | Register number of the base operand |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| imm | input | 16 | Signed immediate |
| pc | input | 32 | Program counter of the instruction |
| acc_size | input | 2 | Access size code: 0 byte, 1 half, 2/3 word |
| short_insn | input | 1 | 1 for 16-bit instruction, 0 for 32-bit |
| shamt | input | 5 | Index shift amount for scaled modes |
| out_valid | output | 1 | Results valid |
| addr | output | 32 | Effective address or branch target |
| wb_data | output | 32 | Base register write-back value |
| wb_en | output | 1 | Base register write-back enable |
| misaligned | output | 1 | Address not a multiple of access size |

## Verification
The assertions assume that `mode`, `base_sel`, `base_val` and `acc_size` are stable while `in_valid` is high. They check the registered result one edge later against these inputs as sampled. Nothing is assumed for idle cycles beyond the zeroed outputs. The bench therefore changes inputs only at falling edges, drives one transaction per cycle, and leaves all inputs at zero while idle. It covers every mode code, including an undefined one, all size codes, base number 0 in update modes, and wrapping at both ends of the address space.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [3:0] {
    AM_DISP       = 4'd0,
    AM_INDIR      = 4'd1,
    AM_INDEX      = 4'd2,
    AM_SCALED     = 4'd3,
    AM_SCALED_UPD = 4'd4,
    AM_DISP_UPD   = 4'd5,
    AM_INDEX_UPD  = 4'd6,
    AM_POST_INC   = 4'd7,
    AM_PRE_DEC    = 4'd8,
    AM_COMPACT    = 4'd9,
    AM_PC_REL     = 4'd10
  } amode_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD2 = 2'd3
  } asize_e;

  // log2 of the access size in bytes
  function automatic logic [1:0] size_log2(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/agu_operand.sv
module agu_operand
  import agu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int SEL_W = 5
) (
  input  logic [SEL_W-1:0] base_sel,
  input  logic [XLEN-1:0]  base_val,
  input  logic [IMM_W-1:0] imm,
  input  logic [1:0]       acc_size,
  input  logic             short_insn,
  output logic [XLEN-1:0]  base_eff,
  output logic             base_live,
  output logic [XLEN-1:0]  imm_sx,
  output logic [XLEN-1:0]  imm_compact,
  output logic [XLEN-1:0]  imm_branch,
  output logic [XLEN-1:0]  step_bytes
);

  localparam int EXT_W = XLEN - IMM_W;

  logic [1:0] lg;

  always_comb begin
    base_live   = (base_sel != '0);
    base_eff    = base_live ? base_val : '0;
    imm_sx      = {{EXT_W{imm[IMM_W-1]}}, imm};
    lg          = size_log2(acc_size);
    imm_compact = imm_sx << lg;
    imm_branch  = short_insn ? (imm_sx << 1) : (imm_sx << 2);
    step_bytes  = XLEN'(1) << lg;
  end

endmodule

// File: rtl/agu_calc.sv
module agu_calc
  import agu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int SH_W  = 5
) (
  input  logic [3:0]      mode,
  input  logic            base_live,
  input  logic [XLEN-1:0] base_eff,
  input  logic [XLEN-1:0] index_val,
  input  logic [SH_W-1:0] shamt,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] imm_sx,
  input  logic [XLEN-1:0] imm_compact,
  input  logic [XLEN-1:0] imm_branch,
  input  logic [XLEN-1:0] step_bytes,
  input  logic [1:0]      acc_size,
  output logic [XLEN-1:0] addr_nxt,
  output logic [XLEN-1:0] wb_nxt,
  output logic            wb_en_nxt,
  output logic            mis_nxt
);

  logic [XLEN-1:0] sum_disp;
  logic [XLEN-1:0] sum_index;
  logic [XLEN-1:0] sum_scaled;
  logic [XLEN-1:0] sum_compact;
  logic [XLEN-1:0] sum_branch;
  logic [XLEN-1:0] base_inc;
  logic [XLEN-1:0] base_dec;
  logic [XLEN-1:0] wb_raw;
  logic            upd;
  amode_e          m;

  always_comb begin
    m           = amode_e'(mode);
    sum_disp    = base_eff + imm_sx;
    sum_index   = base_eff + index_val;
    sum_scaled  = base_eff + (index_val << shamt);
    sum_compact = base_eff + imm_compact;
    sum_branch  = pc + imm_branch;
    base_inc    = base_eff + step_bytes;
    base_dec    = base_eff - step_bytes;

    addr_nxt = sum_disp;
    wb_raw   = '0;
    upd      = 1'b0;
    case (m)
      AM_DISP:       addr_nxt = sum_disp;
      AM_INDIR:      addr_nxt = base_eff;
      AM_INDEX:      addr_nxt = sum_index;
      AM_SCALED:     addr_nxt = sum_scaled;
      AM_SCALED_UPD: begin addr_nxt = sum_scaled; wb_raw = sum_scaled; upd = 1'b1; end
      AM_DISP_UPD:   begin addr_nxt = sum_disp;   wb_raw = sum_disp;   upd = 1'b1; end
      AM_INDEX_UPD:  begin addr_nxt = sum_index;  wb_raw = sum_index;  upd = 1'b1; end
      AM_POST_INC:   begin addr_nxt = base_eff;   wb_raw = base_inc;   upd = 1'b1; end
      AM_PRE_DEC:    begin addr_nxt = base_dec;   wb_raw = base_dec;   upd = 1'b1; end
      AM_COMPACT:    addr_nxt = sum_compact;
      AM_PC_REL:     addr_nxt = sum_branch;
      default:       addr_nxt = sum_disp;
    endcase

    wb_en_nxt = upd && base_live;
    wb_nxt    = wb_en_nxt ? wb_raw : '0;

    case (acc_size)
      2'd0:    mis_nxt = 1'b0;
      2'd1:    mis_nxt = addr_nxt[0];
      default: mis_nxt = |addr_nxt[1:0];
    endcase
  end

endmodule

// File: rtl/agu_out_reg.sv
module agu_out_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XLEN-1:0] addr_nxt,
  input  logic [XLEN-1:0] wb_nxt,
  input  logic            wb_en_nxt,
  input  logic            mis_nxt,
  output logic            out_valid,
  output logic [XLEN-1:0] addr,
  output logic [XLEN-1:0] wb_data,
  output logic            wb_en,
  output logic            misaligned
);

  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      out_valid  <= 1'b0;
      addr       <= '0;
      wb_data    <= '0;
      wb_en      <= 1'b0;
      misaligned <= 1'b0;
    end else begin
      out_valid  <= 1'b1;
      addr       <= addr_nxt;
      wb_data    <= wb_nxt;
      wb_en      <= wb_en_nxt;
      misaligned <= mis_nxt;
    end
  end

endmodule

// File: rtl/agu_top.sv
module agu_top #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int SEL_W = 5,
  parameter int SH_W  = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [3:0]       mode,
  input  logic [SEL_W-1:0] base_sel,
  input  logic [XLEN-1:0]  base_val,
  input  logic [XLEN-1:0]  index_val,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  pc,
  input  logic [1:0]       acc_size,
  input  logic             short_insn,
  input  logic [SH_W-1:0]  shamt,
  output logic             out_valid,
  output logic [XLEN-1:0]  addr,
  output logic [XLEN-1:0]  wb_data,
  output logic             wb_en,
  output logic             misaligned
);

  logic [XLEN-1:0] base_eff;
  logic            base_live;
  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] imm_compact;
  logic [XLEN-1:0] imm_branch;
  logic [XLEN-1:0] step_bytes;
  logic [XLEN-1:0] addr_nxt;
  logic [XLEN-1:0] wb_nxt;
  logic            wb_en_nxt;
  logic            mis_nxt;

  agu_operand #(.XLEN(XLEN), .IMM_W(IMM_W), .SEL_W(SEL_W)) u_operand (
    .base_sel    (base_sel),
    .base_val    (base_val),
    .imm         (imm),
    .acc_size    (acc_size),
    .short_insn  (short_insn),
    .base_eff    (base_eff),
    .base_live   (base_live),
    .imm_sx      (imm_sx),
    .imm_compact (imm_compact),
    .imm_branch  (imm_branch),
    .step_bytes  (step_bytes)
  );

  agu_calc #(.XLEN(XLEN), .SH_W(SH_W)) u_calc (
    .mode        (mode),
    .base_live   (base_live),
    .base_eff    (base_eff),
    .index_val   (index_val),
    .shamt       (shamt),
    .pc          (pc),
    .imm_sx      (imm_sx),
    .imm_compact (imm_compact),
    .imm_branch  (imm_branch),
    .step_bytes  (step_bytes),
    .acc_size    (acc_size),
    .addr_nxt    (addr_nxt),
    .wb_nxt      (wb_nxt),
    .wb_en_nxt   (wb_en_nxt),
    .mis_nxt     (mis_nxt)
  );

  agu_out_reg #(.XLEN(XLEN)) u_out (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .addr_nxt   (addr_nxt),
    .wb_nxt     (wb_nxt),
    .wb_en_nxt  (wb_en_nxt),
    .mis_nxt    (mis_nxt),
    .out_valid  (out_valid),
    .addr       (addr),
    .wb_data    (wb_data),
    .wb_en      (wb_en),
    .misaligned (misaligned)
  );

endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int XLEN  = 32,
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [3:0]       mode,
  input logic [SEL_W-1:0] base_sel,
  input logic [XLEN-1:0]  base_val,
  input logic [1:0]       acc_size,
  input logic             out_valid,
  input logic [XLEN-1:0]  addr,
  input logic [XLEN-1:0]  wb_data,
  input logic             wb_en,
  input logic             misaligned
);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wb_en && addr == '0 && wb_data == '0 && !misaligned));

  p_zero_base_no_wb_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && base_sel == '0) |=> !wb_en);

  p_pcrel_no_wb_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 4'd10) |=> !wb_en);

  p_indirect_base_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 4'd1 && base_sel != '0) |=> addr == $past(base_val));

  p_postinc_step_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 4'd7 && base_sel != '0)
      |=> (wb_en && addr == $past(base_val)
           && wb_data == addr + ((XLEN'(1)) << (($past(acc_size) == 2'd0) ? 0 :
                                                 ($past(acc_size) == 2'd1) ? 1 : 2))));

  p_predec_same_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 4'd8 && base_sel != '0) |=> (wb_en && wb_data == addr));

  p_wb_off_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !wb_en |-> wb_data == '0);

  p_misalign_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> misaligned == (($past(acc_size) == 2'd0) ? 1'b0 :
                                ($past(acc_size) == 2'd1) ? addr[0] : (|addr[1:0])));

endmodule

bind agu_top agu_checker #(.XLEN(XLEN), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .mode       (mode),
  .base_sel   (base_sel),
  .base_val   (base_val),
  .acc_size   (acc_size),
  .out_valid  (out_valid),
  .addr       (addr),
  .wb_data    (wb_data),
  .wb_en      (wb_en),
  .misaligned (misaligned)
);

// File: tb/agu_top_bench.sv
`timescale 1ns/1ps
module agu_top_bench;

  typedef struct packed {
    logic [3:0]  mode;
    logic [4:0]  sel;
    logic [31:0] base;
    logic [31:0] idx;
    logic [15:0] imm;
    logic [31:0] pc;
    logic [1:0]  size;
    logic        sh;
    logic [4:0]  shamt;
    logic [31:0] eaddr;
    logic        ewe;
    logic [31:0] ewb;
    logic        emis;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    // R3 displacement, negative immediate (R11)
    '{4'd0, 5'd3, 32'h00001000, 32'h0, 16'hFFF0, 32'h0, 2'd2, 1'b0, 5'd0, 32'h00000FF0, 1'b0, 32'h0, 1'b0, 8'd3},
    // R2 base number 0 gives absolute address
    '{4'd0, 5'd0, 32'hDEADBEEF, 32'h0, 16'h0123, 32'h0, 2'd0, 1'b0, 5'd0, 32'h00000123, 1'b0, 32'h0, 1'b0, 8'd2},
    // R3 indirect ignores immediate, R10 misaligned word
    '{4'd1, 5'd5, 32'h00002002, 32'h0, 16'h7FFF, 32'h0, 2'd2, 1'b0, 5'd0, 32'h00002002, 1'b0, 32'h0, 1'b1, 8'd3},
    // R4 indexed
    '{4'd2, 5'd1, 32'h00000100, 32'h20, 16'h0, 32'h0, 2'd1, 1'b0, 5'd0, 32'h00000120, 1'b0, 32'h0, 1'b0, 8'd4},
    // R4 scaled, shift 4
    '{4'd3, 5'd2, 32'h00001000, 32'h3, 16'h0, 32'h0, 2'd2, 1'b0, 5'd4, 32'h00001030, 1'b0, 32'h0, 1'b0, 8'd4},
    // R7 scaled with update
    '{4'd4, 5'd2, 32'h00001000, 32'h5, 16'h0, 32'h0, 2'd2, 1'b0, 5'd2, 32'h00001014, 1'b1, 32'h00001014, 1'b0, 8'd7},
    // R7 displacement with update, wraps (R11)
    '{4'd5, 5'd7, 32'hFFFFFFF8, 32'h0, 16'h0010, 32'h0, 2'd2, 1'b0, 5'd0, 32'h00000008, 1'b1, 32'h00000008, 1'b0, 8'd7},
    // R9 indexed update with base number 0 suppressed
    '{4'd6, 5'd0, 32'h12345678, 32'h44, 16'h0, 32'h0, 2'd2, 1'b0, 5'd0, 32'h00000044, 1'b0, 32'h0, 1'b0, 8'd9},
    // R8 post-increment halfword
    '{4'd7, 5'd4, 32'h00003000, 32'h0, 16'h0, 32'h0, 2'd1, 1'b0, 5'd0, 32'h00003000, 1'b1, 32'h00003002, 1'b0, 8'd8},
    // R8 pre-decrement word
    '{4'd8, 5'd4, 32'h00003000, 32'h0, 16'h0, 32'h0, 2'd2, 1'b0, 5'd0, 32'h00002FFC, 1'b1, 32'h00002FFC, 1'b0, 8'd8},
    // R8 post-increment byte wraps to zero
    '{4'd7, 5'd6, 32'hFFFFFFFF, 32'h0, 16'h0, 32'h0, 2'd0, 1'b0, 5'd0, 32'hFFFFFFFF, 1'b1, 32'h00000000, 1'b0, 8'd8},
    // R5 compact byte unscaled, negative
    '{4'd9, 5'd1, 32'h00000100, 32'h0, 16'hFFFF, 32'h0, 2'd0, 1'b0, 5'd0, 32'h000000FF, 1'b0, 32'h0, 1'b0, 8'd5},
    // R5 compact half, shift 1
    '{4'd9, 5'd1, 32'h00000100, 32'h0, 16'h0003, 32'h0, 2'd1, 1'b0, 5'd0, 32'h00000106, 1'b0, 32'h0, 1'b0, 8'd5},
    // R5 compact word, negative shift 2
    '{4'd9, 5'd1, 32'h00000100, 32'h0, 16'hFFFE, 32'h0, 2'd2, 1'b0, 5'd0, 32'h000000F8, 1'b0, 32'h0, 1'b0, 8'd5},
    // R6 PC-relative, long instruction
    '{4'd10, 5'd9, 32'h0, 32'h0, 16'hFFFF, 32'h00000400, 2'd2, 1'b0, 5'd0, 32'h000003FC, 1'b0, 32'h0, 1'b0, 8'd6},
    // R6 PC-relative, short instruction
    '{4'd10, 5'd9, 32'h0, 32'h0, 16'h0005, 32'h00000400, 2'd1, 1'b1, 5'd0, 32'h0000040A, 1'b0, 32'h0, 1'b0, 8'd6},
    // R3 undefined mode code behaves as displacement
    '{4'd15, 5'd3, 32'h00000010, 32'h0, 16'h0004, 32'h0, 2'd3, 1'b0, 5'd0, 32'h00000014, 1'b0, 32'h0, 1'b0, 8'd3},
    // R9 pre-decrement with base number 0: address only
    '{4'd8, 5'd0, 32'h00005555, 32'h0, 16'h0, 32'h0, 2'd2, 1'b0, 5'd0, 32'hFFFFFFFC, 1'b0, 32'h0, 1'b0, 8'd9},
    // R4 scaled, maximum shift 31
    '{4'd3, 5'd0, 32'h0, 32'h1, 16'h0, 32'h0, 2'd2, 1'b0, 5'd31, 32'h80000000, 1'b0, 32'h0, 1'b0, 8'd4},
    // R10 misaligned halfword
    '{4'd9, 5'd1, 32'h00000101, 32'h0, 16'h0001, 32'h0, 2'd1, 1'b0, 5'd0, 32'h00000103, 1'b0, 32'h0, 1'b1, 8'd10}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  mode;
  logic [4:0]  base_sel;
  logic [31:0] base_val;
  logic [31:0] index_val;
  logic [15:0] imm;
  logic [31:0] pc;
  logic [1:0]  acc_size;
  logic        short_insn;
  logic [4:0]  shamt;
  logic        out_valid;
  logic [31:0] addr;
  logic [31:0] wb_data;
  logic        wb_en;
  logic        misaligned;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  agu_top u_agu_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .base_sel(base_sel),
    .base_val(base_val), .index_val(index_val), .imm(imm), .pc(pc),
    .acc_size(acc_size), .short_insn(short_insn), .shamt(shamt),
    .out_valid(out_valid), .addr(addr), .wb_data(wb_data), .wb_en(wb_en),
    .misaligned(misaligned)
  );

  task automatic check(input string what, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 1'b0; mode = '0; base_sel = '0; base_val = '0; index_val = '0;
    imm = '0; pc = '0; acc_size = '0; short_insn = 1'b0; shamt = '0;
  endtask

  task automatic apply(input vec_t v);
    in_valid = 1'b1; mode = v.mode; base_sel = v.sel; base_val = v.base;
    index_val = v.idx; imm = v.imm; pc = v.pc; acc_size = v.size;
    short_insn = v.sh; shamt = v.shamt;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    in_valid = 1'b1;
    mode = 4'd5; base_sel = 5'd3; base_val = 32'h55;
    repeat (3) @(negedge clk);
    // R1 reset clears outputs even with a request present
    check("reset out_valid", 1, 32'(out_valid), 32'd0);
    check("reset addr", 1, addr, 32'd0);
    check("reset wb_en", 1, 32'(wb_en), 32'd0);
    check("reset wb_data", 1, wb_data, 32'd0);
    idle_inputs();
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      @(negedge clk);
      idle_inputs();
      check("out_valid", 1, 32'(out_valid), 32'd1);
      check("addr", int'(VECS[i].req), addr, VECS[i].eaddr);
      check("wb_en", int'(VECS[i].req), 32'(wb_en), 32'(VECS[i].ewe));
      check("wb_data", int'(VECS[i].req), wb_data, VECS[i].ewb);
      check("misaligned", int'(VECS[i].req), 32'(misaligned), 32'(VECS[i].emis));
    end

    // R1 idle cycle after traffic: all outputs zero
    @(negedge clk);
    check("idle out_valid", 1, 32'(out_valid), 32'd0);
    check("idle addr", 1, addr, 32'd0);
    check("idle wb_en", 1, 32'(wb_en), 32'd0);

    // R1 back-to-back: second result replaces first on the next edge
    apply(VECS[8]);
    @(negedge clk);
    apply(VECS[9]);
    check("b2b first addr", 8, addr, 32'h00003000);
    @(negedge clk);
    idle_inputs();
    check("b2b second addr", 8, addr, 32'h00002FFC);

    // R1 synchronous reset mid-stream clears results
    apply(VECS[5]);
    rst = 1'b1;
    @(negedge clk);
    check("mid reset out_valid", 1, 32'(out_valid), 32'd0);
    check("mid reset wb_en", 1, 32'(wb_en), 32'd0);
    rst = 1'b0;
    idle_inputs();
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule